// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It runs two direction predictors side by side. The local predictor keeps a short record of the recent outcomes of each branch, selected by instruction address. It uses that record to index a table of 3-bit saturating counters. The global predictor uses one shift register that holds the recent outcomes of all branches. That register indexes a table of 2-bit saturating counters. A chooser table of 2-bit counters, indexed by the same global history, decides which of the two predictors to follow for each lookup.

The fetch side presents an instruction address with a valid strobe. The address is registered, and the guess is formed combinationally from the registered address and the present table contents. The resolve side presents a branch address and its real outcome. On that clock edge every table is updated from non-speculative state: both counters, the chooser when the two predictors disagreed, and both histories. After reset, a small two-state machine (CLEAR, RUN) sweeps every table entry to its initial value, one index per cycle. While it is in CLEAR the block makes no predictions and ignores resolves. When the last index has been written, the CLEAR-to-RUN transition fires and the machine stays in RUN until the next reset.

Top module: `tournament_predictor`

## Requirements
- R1: After reset is released the machine is in CLEAR and `ready` stays low for exactly 2^12 = 4096 rising edges (the largest table). It then moves to RUN, and `ready` stays high until the next reset. `pred_valid` is never high while `ready` is low.
- R2: Once `ready` rises after a reset, every lookup predicts not-taken. All counters start weakly not-taken (3-bit value 3, 2-bit value 1), all histories start at zero, and the chooser starts at 1, which means weakly trusting local.
- R3: When `fetch_valid` is high at a rising edge, `fetch_pc` is captured. From that edge on, `pred_valid` is high and `pred_taken` gives the guess for the captured address. When `fetch_valid` is low at an edge, `pred_valid` is low after it.
- R4: The local guess is the MSB of the 3-bit counter indexed by the 10-bit local history. That history is the one stored at entry `pc[11:2]` of the local history table. Different addresses with equal histories share a counter.
- R5: The global guess is the MSB of the 2-bit counter indexed by the 12-bit global history register.
- R6: The chooser counter at the global-history index selects the global guess when its MSB is 1 and the local guess when its MSB is 0.
- R7: On a resolve, the local and global counters selected by the pre-update histories count up on taken and down on not-taken. They saturate at 0 and at their maximum (7 and 3).
- R8: On a resolve, the chooser counter changes only if the local and global guesses disagree. It increments when the global guess matched the outcome and decrements when the local guess did.
- R9: On a resolve, the outcome (1 = taken) shifts into bit 0 of the addressed local history entry and of the global history register, and older bits move up by one.
- R10: A resolve presented while in CLEAR changes no table and no history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Lookup request strobe |
| fetch_pc | input | 32 | Address to predict |
| resolve_valid | input | 1 | Resolved-branch strobe |
| resolve_pc | input | 32 | Address of the resolved branch |
| resolve_taken | input | 1 | Actual outcome, 1 = taken |
| ready | output | 1 | High in RUN state |
| pred_valid | output | 1 | Guess on `pred_taken` is meaningful |
| pred_taken | output | 1 | Predicted direction, 1 = taken |

## Verification
A guess is due on the first rising edge after its fetch strobe, because one register sits on the path. The bench drives on the falling edge and reads `pred_valid` and `pred_taken` on the following falling edge. A resolve changes the tables on the edge where its strobe is sampled, so the bench always lets that edge pass before the next lookup and compares the result with its own table model. The CLEAR-to-RUN transition is due 4096 edges after reset release, and the bench counts falling edges to confirm that `ready` rises on exactly that one.

// File: rtl/tp_pkg.sv
package tp_pkg;

    typedef enum logic {
        ST_CLEAR = 1'b0,
        ST_RUN   = 1'b1
    } tp_state_e;

endpackage

// File: rtl/tp_sat_table.sv
module tp_sat_table #(
    parameter int IDX_W = 12,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_msb,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_up,
    output logic             upd_msb
);
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [CNT_W-1:0] INIT_VAL = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic [CNT_W-1:0] TOP_VAL  = {CNT_W{1'b1}};

    logic [CNT_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0] upd_cur;
    logic [CNT_W-1:0] upd_nxt;

    assign rd_msb  = mem[rd_idx][CNT_W-1];
    assign upd_cur = mem[upd_idx];
    assign upd_msb = upd_cur[CNT_W-1];

    always_comb begin
        upd_nxt = upd_cur;
        if (upd_up) begin
            if (upd_cur != TOP_VAL) upd_nxt = upd_cur + 1'b1;
        end else begin
            if (upd_cur != '0) upd_nxt = upd_cur - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (clr_en) begin
            mem[clr_idx] <= INIT_VAL;
        end else if (upd_en) begin
            mem[upd_idx] <= upd_nxt;
        end
    end

endmodule

// File: rtl/tp_hist_table.sv
module tp_hist_table #(
    parameter int IDX_W  = 10,
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_hist,
    input  logic              upd_en,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic              upd_bit,
    output logic [HIST_W-1:0] upd_hist
);
    localparam int DEPTH = 1 << IDX_W;

    logic [HIST_W-1:0] mem [DEPTH];

    assign rd_hist  = mem[rd_idx];
    assign upd_hist = mem[upd_idx];

    always_ff @(posedge clk) begin
        if (clr_en) begin
            mem[clr_idx] <= '0;
        end else if (upd_en) begin
            mem[upd_idx] <= {upd_hist[HIST_W-2:0], upd_bit};
        end
    end

endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor
    import tp_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ALIGN   = 2,
    parameter int LIDX_W  = 10,
    parameter int LHIST_W = 10,
    parameter int GHIST_W = 12,
    parameter int LCNT_W  = 3,
    parameter int GCNT_W  = 2,
    parameter int CCNT_W  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch_valid,
    input  logic [PC_W-1:0] fetch_pc,
    input  logic            resolve_valid,
    input  logic [PC_W-1:0] resolve_pc,
    input  logic            resolve_taken,
    output logic            ready,
    output logic            pred_valid,
    output logic            pred_taken
);
    localparam int W_A   = (LIDX_W > LHIST_W) ? LIDX_W : LHIST_W;
    localparam int CLR_W = (W_A > GHIST_W) ? W_A : GHIST_W;
    localparam logic [CLR_W-1:0] CLR_LAST = {CLR_W{1'b1}};

    tp_state_e        state, state_nx;
    logic [CLR_W-1:0] clr_idx, clr_idx_nx;
    logic             clr_en;

    logic              f_valid;
    logic [LIDX_W-1:0] f_lidx;
    logic [LIDX_W-1:0] r_lidx;
    logic [GHIST_W-1:0] ghr;
    logic              upd_go;

    logic [LHIST_W-1:0] f_lhist, r_lhist;
    logic f_lpred, f_gpred, f_choose_g;
    logic r_lpred, r_gpred, r_choose_unused;

    logic unused_pc_bits;
    assign unused_pc_bits = ^{fetch_pc[PC_W-1:ALIGN+LIDX_W], fetch_pc[ALIGN-1:0],
                              resolve_pc[PC_W-1:ALIGN+LIDX_W], resolve_pc[ALIGN-1:0],
                              r_choose_unused};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_CLEAR;
            clr_idx <= '0;
        end else begin
            state   <= state_nx;
            clr_idx <= clr_idx_nx;
        end
    end

    // next-state logic: CLEAR sweeps all indices, then RUN holds
    always_comb begin
        state_nx   = state;
        clr_idx_nx = clr_idx;
        unique case (state)
            ST_CLEAR: begin
                clr_idx_nx = clr_idx + 1'b1;
                if (clr_idx == CLR_LAST) state_nx = ST_RUN;
            end
            ST_RUN: begin
                state_nx = ST_RUN;
            end
        endcase
    end

    // state outputs
    always_comb begin
        ready  = 1'b0;
        clr_en = 1'b0;
        unique case (state)
            ST_CLEAR: clr_en = 1'b1;
            ST_RUN:   ready  = 1'b1;
        endcase
    end

    // fetch address register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_valid <= 1'b0;
            f_lidx  <= '0;
        end else begin
            f_valid <= fetch_valid;
            if (fetch_valid) f_lidx <= fetch_pc[ALIGN +: LIDX_W];
        end
    end

    assign r_lidx = resolve_pc[ALIGN +: LIDX_W];
    assign upd_go = resolve_valid & ready;

    // global history register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ghr <= '0;
        end else if (upd_go) begin
            ghr <= {ghr[GHIST_W-2:0], resolve_taken};
        end
    end

    tp_hist_table #(.IDX_W(LIDX_W), .HIST_W(LHIST_W)) u_lhist (
        .clk      (clk),
        .clr_en   (clr_en),
        .clr_idx  (clr_idx[LIDX_W-1:0]),
        .rd_idx   (f_lidx),
        .rd_hist  (f_lhist),
        .upd_en   (upd_go),
        .upd_idx  (r_lidx),
        .upd_bit  (resolve_taken),
        .upd_hist (r_lhist)
    );

    tp_sat_table #(.IDX_W(LHIST_W), .CNT_W(LCNT_W)) u_lcnt (
        .clk     (clk),
        .clr_en  (clr_en),
        .clr_idx (clr_idx[LHIST_W-1:0]),
        .rd_idx  (f_lhist),
        .rd_msb  (f_lpred),
        .upd_en  (upd_go),
        .upd_idx (r_lhist),
        .upd_up  (resolve_taken),
        .upd_msb (r_lpred)
    );

    tp_sat_table #(.IDX_W(GHIST_W), .CNT_W(GCNT_W)) u_gcnt (
        .clk     (clk),
        .clr_en  (clr_en),
        .clr_idx (clr_idx[GHIST_W-1:0]),
        .rd_idx  (ghr),
        .rd_msb  (f_gpred),
        .upd_en  (upd_go),
        .upd_idx (ghr),
        .upd_up  (resolve_taken),
        .upd_msb (r_gpred)
    );

    // chooser: moves only on disagreement, toward the component that was right
    tp_sat_table #(.IDX_W(GHIST_W), .CNT_W(CCNT_W)) u_choice (
        .clk     (clk),
        .clr_en  (clr_en),
        .clr_idx (clr_idx[GHIST_W-1:0]),
        .rd_idx  (ghr),
        .rd_msb  (f_choose_g),
        .upd_en  (upd_go & (r_lpred != r_gpred)),
        .upd_idx (ghr),
        .upd_up  (r_gpred == resolve_taken),
        .upd_msb (r_choose_unused)
    );

    assign pred_valid = f_valid & ready;
    assign pred_taken = pred_valid & (f_choose_g ? f_gpred : f_lpred);

endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
    parameter int GHIST_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ready,
    input logic               pred_valid,
    input logic               fetch_valid,
    input logic               resolve_valid,
    input logic               resolve_taken,
    input logic [GHIST_W-1:0] ghr
);

    assert_no_pred_in_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !pred_valid);

    assert_ready_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    assert_fetch_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && ready) |=> pred_valid);

    assert_ghr_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (resolve_valid && ready) |=>
            (ghr == {$past(ghr[GHIST_W-2:0]), $past(resolve_taken)}));

    assert_ghr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(resolve_valid && ready) |=> $stable(ghr));

endmodule

bind tournament_predictor tp_checker #(.GHIST_W(GHIST_W)) u_tp_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .ready         (ready),
    .pred_valid    (pred_valid),
    .fetch_valid   (fetch_valid),
    .resolve_valid (resolve_valid),
    .resolve_taken (resolve_taken),
    .ghr           (ghr)
);

// File: tb/tournament_predictor_test.sv
module tournament_predictor_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        resolve_valid = 1'b0;
    logic [31:0] resolve_pc = '0;
    logic        resolve_taken = 1'b0;
    logic        ready, pred_valid, pred_taken;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tournament_predictor uut (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .resolve_valid(resolve_valid), .resolve_pc(resolve_pc),
        .resolve_taken(resolve_taken),
        .ready(ready), .pred_valid(pred_valid), .pred_taken(pred_taken)
    );

    // reference tables built from the requirements
    logic [9:0]  m_lht [1024];
    logic [2:0]  m_lct [1024];
    logic [1:0]  m_gct [4096];
    logic [1:0]  m_cht [4096];
    logic [11:0] m_ghr;

    // stimulus vectors: {taken, pc}; expected guesses come from the model
    localparam logic [32:0] STIM [24] = '{
        {1'b1, 32'h0000_0040}, {1'b0, 32'h0000_0044}, {1'b1, 32'h0000_0080},
        {1'b0, 32'h0000_0040}, {1'b1, 32'h0000_0044}, {1'b1, 32'h0000_0080},
        {1'b1, 32'h0000_0040}, {1'b0, 32'h0000_0044}, {1'b1, 32'h0000_0080},
        {1'b0, 32'h0000_0080}, {1'b1, 32'h0000_1040}, {1'b0, 32'h0000_00C0},
        {1'b0, 32'h0000_0040}, {1'b1, 32'h0000_0044}, {1'b1, 32'h0000_0080},
        {1'b1, 32'h0000_0080}, {1'b1, 32'h0000_0080}, {1'b0, 32'h0000_0080},
        {1'b1, 32'h0000_00C0}, {1'b0, 32'h0000_1040}, {1'b1, 32'h0000_0040},
        {1'b0, 32'h0000_0044}, {1'b1, 32'h0000_0ffc}, {1'b0, 32'h0000_0ffc}
    };

    task automatic model_init();
        for (int i = 0; i < 1024; i++) begin m_lht[i] = '0; m_lct[i] = 3'd3; end
        for (int i = 0; i < 4096; i++) begin m_gct[i] = 2'd1; m_cht[i] = 2'd1; end
        m_ghr = '0;
    endtask

    function automatic logic model_pred(input logic [31:0] pc);
        logic l, g;
        l = m_lct[m_lht[pc[11:2]]][2];
        g = m_gct[m_ghr][1];
        return m_cht[m_ghr][1] ? g : l;
    endfunction

    task automatic model_update(input logic [31:0] pc, input logic t);
        logic [9:0] h;
        logic l, g;
        h = m_lht[pc[11:2]];
        l = m_lct[h][2];
        g = m_gct[m_ghr][1];
        if (l != g) begin
            if (g == t) begin if (m_cht[m_ghr] != 2'd3) m_cht[m_ghr] += 2'd1; end
            else        begin if (m_cht[m_ghr] != 2'd0) m_cht[m_ghr] -= 2'd1; end
        end
        if (t) begin
            if (m_lct[h] != 3'd7) m_lct[h] += 3'd1;
            if (m_gct[m_ghr] != 2'd3) m_gct[m_ghr] += 2'd1;
        end else begin
            if (m_lct[h] != 3'd0) m_lct[h] -= 3'd1;
            if (m_gct[m_ghr] != 2'd0) m_gct[m_ghr] -= 2'd1;
        end
        m_lht[pc[11:2]] = {h[8:0], t};
        m_ghr = {m_ghr[10:0], t};
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // lookup: drive on falling edge, result due after the next rising edge
    task automatic do_fetch(input logic [31:0] pc, input logic exp, input string req);
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_pc    = pc;
        @(negedge clk);
        fetch_valid = 1'b0;
        check({req, " pred_valid"}, {31'd0, pred_valid}, 32'd1);
        check({req, " pred_taken"}, {31'd0, pred_taken}, {31'd0, exp});
    endtask

    task automatic do_resolve(input logic [31:0] pc, input logic t);
        @(negedge clk);
        resolve_valid = 1'b1;
        resolve_pc    = pc;
        resolve_taken = t;
        model_update(pc, t);
        @(negedge clk);
        resolve_valid = 1'b0;
    endtask

    // reset, then count edges through CLEAR while trying lookups and resolves
    task automatic reset_and_clear();
        int cnt;
        @(negedge clk);
        rst_n = 1'b0;
        fetch_valid = 1'b0;
        resolve_valid = 1'b0;
        @(negedge clk);
        model_init();
        rst_n = 1'b1;
        fetch_valid = 1'b1;
        fetch_pc = 32'h0000_0080;
        cnt = 0;
        while (!ready && cnt < 10000) begin
            @(negedge clk);
            cnt++;
            if (cnt == 2000) check("R1 pred_valid low in CLEAR", {31'd0, pred_valid}, 32'd0);
            // R10: taken resolves in the last CLEAR cycles must not land
            resolve_valid = (cnt >= 4090 && cnt < 4096);
            resolve_pc    = 32'h0000_0040;
            resolve_taken = 1'b1;
            if (cnt >= 4096) fetch_valid = 1'b0;
        end
        resolve_valid = 1'b0;
        fetch_valid = 1'b0;
        check("R1 edges until ready", cnt, 32'd4096);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        check("R1 ready low in reset", {31'd0, ready}, 32'd0);
        reset_and_clear();

        // R2 and R10: fresh state predicts not-taken everywhere
        do_fetch(32'h0000_0080, 1'b0, "R2 fresh lookup");
        do_fetch(32'h0000_0040, 1'b0, "R10 resolves in CLEAR ignored");
        do_fetch(32'h0000_3ffc, 1'b0, "R2 fresh lookup high index");

        // R3: no strobe at an edge drops pred_valid
        @(negedge clk);
        check("R3 pred_valid drops", {31'd0, pred_valid}, 32'd0);
        check("R3 pred_taken gated", {31'd0, pred_taken}, 32'd0);

        // R4: one taken at 0x100 makes local counter 0 = 4; 0x200 still has history 0
        do_resolve(32'h0000_0100, 1'b1);
        do_fetch(32'h0000_0200, 1'b1, "R4 shared pattern counter");
        do_fetch(32'h0000_0100, 1'b0, "R9 local history shifted");

        // table walk: several passes for learning
        for (int pass = 0; pass < 6; pass++) begin
            for (int i = 0; i < 24; i++) begin
                do_fetch(STIM[i][31:0], model_pred(STIM[i][31:0]), "R6 R7 R8 R9 walk");
                do_resolve(STIM[i][31:0], STIM[i][32]);
            end
        end

        // R5: global after reset; twelve takens on different branches then lookup
        reset_and_clear();
        for (int i = 0; i < 20; i++) begin
            do_resolve(32'h0000_0300, 1'b1);
            do_fetch(32'h0000_0300, model_pred(32'h0000_0300), "R7 saturate up");
        end
        do_resolve(32'h0000_0300, 1'b0);
        do_fetch(32'h0000_0300, model_pred(32'h0000_0300), "R7 inertia");
        for (int i = 0; i < 12; i++) do_resolve(32'h0000_0400 + 32'(i*4), 1'b1);
        do_fetch(32'h0000_0500, model_pred(32'h0000_0500), "R5 global history lookup");
        for (int i = 0; i < 16; i++) begin
            do_resolve(32'h0000_0300, 1'b0);
            do_fetch(32'h0000_0300, model_pred(32'h0000_0300), "R7 saturate down");
        end
        for (int i = 0; i < 20; i++) begin
            do_resolve(32'h0000_0600 + 32'((i % 3) * 4), (i % 3) != 1);
            do_fetch(32'h0000_0604, model_pred(32'h0000_0604), "R8 chooser training");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule